// File: doc/BRIEF.md
# Shifting Byte Queue with Byte/Halfword Host Access

This block is a four-entry byte queue. It sits between a host register port and the byte engine of a two-wire serial bus. The host can put data in or take it out one byte or two bytes at a time. The bus engine pushes each byte it receives and pops each byte it sends, one at a time. Entry 1 is always the head. Whenever bytes are taken out, the remaining bytes move down toward the head in the same clock cycle.

A chip uses two copies of the block: one for transfers the device starts itself and one for transfers it answers as a target. Both copies behave the same way. The queue reports how many bytes it holds and has empty and full flags. A synchronous flush input empties it.

When the queue is full, a write is dropped. When the queue is empty, a read returns whatever is left in the head entries and the count does not change. Firmware should therefore flush the queue before it starts a new read transfer.

Top module: `hw_byte_queue`

## Requirements
- R1: After reset the count is 0, `empty` is 1, `full` is 0, and `host_rd_data` and `bus_head` are all zeros.
- R2: A single-byte write (`host_wr_data[7:0]`) or a bus push stores the byte in the first free entry. The head is always the oldest byte held.
- R3: A double-byte write stores `host_wr_data[15:8]` first and `host_wr_data[7:0]` second, so the upper byte leaves the queue first.
- R4: Bytes that find no free entry are discarded. A write to a full queue changes neither the count nor the contents. A double-byte write with one free entry keeps only the upper byte.
- R5: A single-byte read or a bus pop removes the head. Every remaining byte moves down one entry and the count drops by 1.
- R6: A double-byte read presents entry 1 on `host_rd_data[15:8]` and entry 2 on `host_rd_data[7:0]`. It then removes two bytes, and entries 3 and 4 move to entries 1 and 2. If only one byte is held, the queue becomes empty.
- R7: A read of an empty queue leaves the count at 0 and leaves the entries unchanged. The read data therefore repeats the stale head values.
- R8: When a push and a pop happen in the same cycle, the pop is applied first. The pushed bytes then fill the space that is free after the pop. With one byte in each direction the count stays the same, even when the queue is full.
- R9: `flush` sets the count to 0 at the next edge. It has priority over any push or pop in the same cycle.
- R10: When the host and the bus request the same direction (push or pop) in the same cycle, the host request is served and the bus request is ignored.
- R11: `empty` is 1 exactly when the count is 0, and `full` is 1 exactly when the count is 4. The count never exceeds 4.
- R12: `host_rd_data` and `bus_head` show the current entries without delay. A reader samples them in the cycle in which it requests the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue at the next edge |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_pair | input | 1 | 1 = write two bytes, 0 = write one byte |
| host_wr_data | input | 16 | Write data; upper byte goes in first on a pair write, byte [7:0] is used on a single write |
| host_rd_en | input | 1 | Host read strobe (pops) |
| host_rd_pair | input | 1 | 1 = read two bytes, 0 = read one byte |
| host_rd_data | output | 16 | {entry 1, entry 2} |
| bus_push | input | 1 | Bus engine stores a received byte |
| bus_push_data | input | 8 | Received byte |
| bus_pop | input | 1 | Bus engine consumes the head byte |
| bus_head | output | 8 | Entry 1, the next byte to send |
| count | output | 3 | Number of bytes held (0 to 4) |
| empty | output | 1 | Count is 0 |
| full | output | 1 | Count is 4 |

## Verification
A fault in the shift logic shows on `bus_head` and `host_rd_data` one cycle after the pop that caused it. A byte lost or duplicated in the queue shows up at the latest when the queue drains, because the output order no longer matches the order of the writes. A fault in the count logic shows on `count`, `empty` and `full` in the cycle right after the faulty edge. It also shows later as a write that is wrongly accepted or wrongly dropped at the full boundary, and as a pop that wrongly changes the stages of an empty queue.

// File: rtl/hwq_pkg.sv
package hwq_pkg;
    typedef enum logic [1:0] {
        XFER_NONE = 2'd0,
        XFER_ONE  = 2'd1,
        XFER_TWO  = 2'd2
    } xfer_e;
endpackage

// File: rtl/hwq_req_merge.sv
module hwq_req_merge
    import hwq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            host_wr_en,
    input  logic            host_wr_pair,
    input  logic [2*DW-1:0] host_wr_data,
    input  logic            host_rd_en,
    input  logic            host_rd_pair,
    input  logic            bus_push,
    input  logic [DW-1:0]   bus_push_data,
    input  logic            bus_pop,
    output xfer_e           push_n,
    output logic [DW-1:0]   push_b0,
    output logic [DW-1:0]   push_b1,
    output xfer_e           pop_n
);
    // Host has priority over the bus on each side independently (R10)
    always_comb begin
        push_n  = XFER_NONE;
        push_b0 = '0;
        push_b1 = '0;
        if (host_wr_en) begin
            if (host_wr_pair) begin
                push_n  = XFER_TWO;
                push_b0 = host_wr_data[2*DW-1:DW];
                push_b1 = host_wr_data[DW-1:0];
            end else begin
                push_n  = XFER_ONE;
                push_b0 = host_wr_data[DW-1:0];
            end
        end else if (bus_push) begin
            push_n  = XFER_ONE;
            push_b0 = bus_push_data;
        end
    end

    always_comb begin
        pop_n = XFER_NONE;
        if (host_rd_en)   pop_n = host_rd_pair ? XFER_TWO : XFER_ONE;
        else if (bus_pop) pop_n = XFER_ONE;
    end
endmodule

// File: rtl/hwq_core.sv
module hwq_core
    import hwq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  xfer_e                     push_n,
    input  logic [DW-1:0]             push_b0,
    input  logic [DW-1:0]             push_b1,
    input  xfer_e                     pop_n,
    output logic [DEPTH-1:0][DW-1:0]  stage_o,
    output logic [CNT_W-1:0]          count_o
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] st;
        logic [CNT_W-1:0]         cnt;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        int cnt_i;
        int pop_i;
        int base_i;
        int acc_i;
        state_d = state_q;
        cnt_i   = int'(state_q.cnt);
        pop_i   = (int'(pop_n) > cnt_i) ? cnt_i : int'(pop_n);
        base_i  = cnt_i - pop_i;
        acc_i   = DEPTH - base_i;
        if (int'(push_n) < acc_i) acc_i = int'(push_n);
        for (int i = 0; i < DEPTH; i++) begin
            if (i + pop_i < cnt_i)
                state_d.st[i] = state_q.st[IDX_W'(i + pop_i)];
            if (i >= base_i && i < base_i + acc_i)
                state_d.st[i] = (i == base_i) ? push_b0 : push_b1;
        end
        state_d.cnt = CNT_W'(base_i + acc_i);
        if (flush) state_d.cnt = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign stage_o = state_q.st;
    assign count_o = state_q.cnt;

    // R11
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(state_q.cnt) <= DEPTH);

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> state_q.cnt == '0);

    // R7
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && state_q.cnt == '0 && pop_n != XFER_NONE && push_n == XFER_NONE)
        |=> (state_q.cnt == '0 && $stable(state_q.st)));

    // R4
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && int'(state_q.cnt) == DEPTH && pop_n == XFER_NONE && push_n != XFER_NONE)
        |=> (int'(state_q.cnt) == DEPTH && $stable(state_q.st)));

    // R8
    balanced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && push_n == XFER_ONE && pop_n == XFER_ONE && state_q.cnt != '0)
        |=> $stable(state_q.cnt));

    // R5
    shift_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && push_n == XFER_NONE && pop_n == XFER_ONE && int'(state_q.cnt) >= 2)
        |=> state_q.st[0] == $past(state_q.st[1]));
endmodule

// File: rtl/hw_byte_queue.sv
module hw_byte_queue
    import hwq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            host_wr_en,
    input  logic            host_wr_pair,
    input  logic [2*DW-1:0] host_wr_data,
    input  logic            host_rd_en,
    input  logic            host_rd_pair,
    output logic [2*DW-1:0] host_rd_data,
    input  logic            bus_push,
    input  logic [DW-1:0]   bus_push_data,
    input  logic            bus_pop,
    output logic [DW-1:0]   bus_head,
    output logic [CNT_W-1:0] count,
    output logic            empty,
    output logic            full
);
    xfer_e                    push_n, pop_n;
    logic [DW-1:0]            push_b0, push_b1;
    logic [DEPTH-1:0][DW-1:0] stage;

    hwq_req_merge #(.DW(DW)) u_merge (
        .host_wr_en    (host_wr_en),
        .host_wr_pair  (host_wr_pair),
        .host_wr_data  (host_wr_data),
        .host_rd_en    (host_rd_en),
        .host_rd_pair  (host_rd_pair),
        .bus_push      (bus_push),
        .bus_push_data (bus_push_data),
        .bus_pop       (bus_pop),
        .push_n        (push_n),
        .push_b0       (push_b0),
        .push_b1       (push_b1),
        .pop_n         (pop_n)
    );

    hwq_core #(.DW(DW), .DEPTH(DEPTH)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .push_n  (push_n),
        .push_b0 (push_b0),
        .push_b1 (push_b1),
        .pop_n   (pop_n),
        .stage_o (stage),
        .count_o (count)
    );

    assign host_rd_data = {stage[0], stage[1]};
    assign bus_head     = stage[0];
    assign empty        = (count == '0);
    assign full         = (int'(count) == DEPTH);
endmodule

// File: tb/hw_byte_queue_tb.sv
`timescale 1ns/1ps
module hw_byte_queue_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        host_wr_en = 1'b0, host_wr_pair = 1'b0;
    logic [15:0] host_wr_data = '0;
    logic        host_rd_en = 1'b0, host_rd_pair = 1'b0;
    logic [15:0] host_rd_data;
    logic        bus_push = 1'b0, bus_pop = 1'b0;
    logic [7:0]  bus_push_data = '0;
    logic [7:0]  bus_head;
    logic [2:0]  count;
    logic        empty, full;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m [4];
    int         mc;

    always #4 clk = ~clk;

    hw_byte_queue u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .host_wr_en(host_wr_en), .host_wr_pair(host_wr_pair), .host_wr_data(host_wr_data),
        .host_rd_en(host_rd_en), .host_rd_pair(host_rd_pair), .host_rd_data(host_rd_data),
        .bus_push(bus_push), .bus_push_data(bus_push_data), .bus_pop(bus_pop),
        .bus_head(bus_head), .count(count), .empty(empty), .full(full)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected next state from the requirements (R2..R10)
    task automatic model_step();
        int npush, npop, base, acc;
        logic [7:0] b0, b1;
        logic [7:0] nm [4];
        npush = 0; b0 = '0; b1 = '0;
        if (host_wr_en) begin
            npush = host_wr_pair ? 2 : 1;
            b0 = host_wr_pair ? host_wr_data[15:8] : host_wr_data[7:0];
            b1 = host_wr_data[7:0];
        end else if (bus_push) begin
            npush = 1; b0 = bus_push_data;
        end
        npop = host_rd_en ? (host_rd_pair ? 2 : 1) : (bus_pop ? 1 : 0);
        if (npop > mc) npop = mc;
        base = mc - npop;
        acc = 4 - base;
        if (npush < acc) acc = npush;
        for (int i = 0; i < 4; i++) begin
            nm[i] = m[i];
            if (i + npop < mc) nm[i] = m[i + npop];
            if (i >= base && i < base + acc) nm[i] = (i == base) ? b0 : b1;
        end
        for (int i = 0; i < 4; i++) m[i] = nm[i];
        mc = flush ? 0 : base + acc;
    endtask

    task automatic idle_inputs();
        flush = 0; host_wr_en = 0; host_wr_pair = 0; host_rd_en = 0;
        host_rd_pair = 0; bus_push = 0; bus_pop = 0;
    endtask

    // Apply the currently driven inputs for one edge, then sample at negedge
    task automatic step(input bit cmp);
        if (rst_n) model_step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        if (cmp) begin
            chk("R12 head", {24'd0, bus_head}, {24'd0, m[0]});
            chk("R12 rd_data", {16'd0, host_rd_data}, {16'd0, m[0], m[1]});
            chk("R11 count", {29'd0, count}, mc);
            chk("R11 empty", {31'd0, empty}, {31'd0, mc == 0});
            chk("R11 full", {31'd0, full}, {31'd0, mc == 4});
        end
    endtask

    task automatic wr(input bit pair, input logic [15:0] d);
        host_wr_en = 1; host_wr_pair = pair; host_wr_data = d; step(0);
    endtask
    task automatic rd(input bit pair);
        host_rd_en = 1; host_rd_pair = pair; step(0);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) m[i] = '0;
        mc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk("R1 count", {29'd0, count}, 0);
        chk("R1 empty", {31'd0, empty}, 1);
        chk("R1 full", {31'd0, full}, 0);
        chk("R1 rd_data", {16'd0, host_rd_data}, 0);
        chk("R1 head", {24'd0, bus_head}, 0);

        // R2 bus pushes in arrival order
        bus_push = 1; bus_push_data = 8'h11; step(0);
        bus_push = 1; bus_push_data = 8'h22; step(0);
        chk("R2 head", {24'd0, bus_head}, 32'h11);
        chk("R2 rd_data", {16'd0, host_rd_data}, 32'h1122);
        // R3 pair write, upper byte first
        wr(1, 16'hA1B2);
        chk("R11 full", {31'd0, full}, 1);
        chk("R3 count", {29'd0, count}, 4);
        // R5 single pop shifts down
        bus_pop = 1; step(0);
        chk("R5 rd_data", {16'd0, host_rd_data}, 32'h22A1);
        chk("R5 count", {29'd0, count}, 3);
        wr(0, 16'h0033);
        // R4 write while full dropped
        wr(0, 16'h0044);
        chk("R4 count", {29'd0, count}, 4);
        chk("R6 rd_data before", {16'd0, host_rd_data}, 32'h22A1);
        rd(1);
        // R3/R6 entries 3,4 move to 1,2
        chk("R6 rd_data", {16'd0, host_rd_data}, 32'hB233);
        chk("R6 count", {29'd0, count}, 2);
        // R4 pair write with one free entry keeps upper byte
        wr(0, 16'h0055);
        wr(1, 16'h6677);
        chk("R4 count", {29'd0, count}, 4);
        rd(1);
        chk("R4 rd_data", {16'd0, host_rd_data}, 32'h5566);
        rd(1);
        chk("R6 empty", {31'd0, empty}, 1);
        // R7 empty read repeats stale head
        rd(1);
        chk("R7 rd_data", {16'd0, host_rd_data}, 32'h5566);
        chk("R7 count", {29'd0, count}, 0);
        // R6 pair read with one byte present
        wr(0, 16'h0099);
        chk("R6 rd_data one", {16'd0, host_rd_data}, 32'h9966);
        rd(1);
        chk("R6 one-byte empty", {31'd0, empty}, 1);
        chk("R7 stale", {16'd0, host_rd_data}, 32'h9966);
        // R8 push and pop together while full
        wr(1, 16'h0102);
        wr(1, 16'h0304);
        host_wr_en = 1; host_wr_data = 16'h0005; bus_pop = 1; step(0);
        chk("R8 count", {29'd0, count}, 4);
        chk("R8 rd_data", {16'd0, host_rd_data}, 32'h0203);
        // R9 flush beats a write
        flush = 1; host_wr_en = 1; host_wr_data = 16'h00EE; step(0);
        chk("R9 count", {29'd0, count}, 0);
        chk("R9 empty", {31'd0, empty}, 1);
        // R10 host write wins over bus push
        host_wr_en = 1; host_wr_data = 16'h00C0; bus_push = 1; bus_push_data = 8'hD0; step(0);
        chk("R10 count", {29'd0, count}, 1);
        chk("R10 head", {24'd0, bus_head}, 32'hC0);
        // R10 host read wins over bus pop: pair read takes both
        wr(0, 16'h00C1);
        host_rd_en = 1; host_rd_pair = 1; bus_pop = 1; step(0);
        chk("R10 pop count", {29'd0, count}, 0);

        // Random phase compared against the model every cycle
        for (int k = 0; k < 3000; k++) begin
            flush         = ($urandom % 32) == 0;
            host_wr_en    = ($urandom % 4) == 0;
            host_wr_pair  = $urandom % 2;
            host_wr_data  = 16'($urandom);
            host_rd_en    = ($urandom % 4) == 0;
            host_rd_pair  = $urandom % 2;
            bus_push      = ($urandom % 3) == 0;
            bus_push_data = 8'($urandom);
            bus_pop       = ($urandom % 3) == 0;
            step(1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule